// File: doc/BRIEF.md
# Multi-Mode Integer Compare Unit

This execution block compares two 64-bit operands and produces a 4-bit condition field. The second operand can instead be a 16-bit immediate, sign-extended to 64 bits. A 4-bit mode code selects one of eleven comparisons:

- Unsigned or signed magnitude compares at 64, 32, 16 or 8 bits.
- A test of whether one byte falls inside one inclusive range.
- The same test against two inclusive ranges.
- A search for one byte among all eight bytes of the second operand.

The incoming summary-overflow bit is passed into the field for the magnitude compares.

An issue strobe qualifies the inputs. The unit registers the result once, so the condition field and a valid strobe appear one clock after the issue. Between issues the field keeps its last value. Operand fetch, renaming and the write into a condition register file belong to the neighbouring blocks.

Top module: `cmpu_core`

## Requirements
- R1: While rst_n is low, res_valid is 0 and cond is 4'b0000.
- R2: res_valid is high in exactly the cycle after each cycle with issue_valid high. cond carries that issue's result in the same cycle. No output changes before that clock edge.
- R3: The bit layout of cond is {LT, GT, EQ, SO}, with bit 3 as LT and bit 0 as SO. In mode codes 0 to 7, exactly one of LT, GT or EQ is set, and SO equals so_in.
- R4: Codes 0 to 7 select the width from code bits [2:1]: 0 is 64 bits, 1 is 32, 2 is 16 and 3 is 8. Code bit 0 selects signed (1) or unsigned (0). Only the low bits of each operand up to the selected width take part.
- R5: With use_imm high, the second operand is imm sign-extended to 64 bits, and opnd_b is ignored. This applies in every mode.
- R6: Code 8 is the single-range test. GT is set when opnd_a[7:0] lies within the inclusive range from B[7:0] (low bound) to B[15:8] (high bound), where B is the selected second operand. LT, EQ and SO are 0, and opnd_a[63:8] is ignored.
- R7: Code 9 is the dual-range test. It uses the range of R6 and a second range from B[23:16] (low bound) to B[31:24] (high bound). GT is set if the byte lies in either range.
- R8: Code 10 is the byte search. GT is set when opnd_a[7:0] equals any of the eight bytes of B, and the other bits are 0.
- R9: Codes 11 to 15 produce cond 4'b0000, with res_valid still raised.
- R10: While issue_valid is low, cond holds its last value whatever the other inputs do.
- R11: A range whose low bound exceeds its high bound matches no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Qualifies the operation inputs this cycle |
| mode | input | 4 | Compare mode code, 0 to 10 |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, register form |
| imm | input | 16 | Signed immediate, used when use_imm is high |
| use_imm | input | 1 | Selects the sign-extended immediate as the second operand |
| so_in | input | 1 | Incoming summary-overflow bit |
| res_valid | output | 1 | Result strobe, one cycle after issue |
| cond | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
Every compare result is due exactly one rising edge after its issue cycle. The bench drives each vector at a falling edge and samples res_valid and cond at the next falling edge. Vectors follow one another back to back, so the single-cycle latency is exercised under continuous issue. One directed test samples cond shortly after driving a new operation, before any edge, to show the field has not yet moved. Idle cycles are checked for a dropped strobe and an unchanged field.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

  localparam int MODE_W = 4;
  localparam int COND_W = 4;
  localparam int BYTE_W = 8;

  // Condition field bit positions, consumed by the register file writer.
  localparam int CB_LT = 3;
  localparam int CB_GT = 2;
  localparam int CB_EQ = 1;
  localparam int CB_SO = 0;

  // Code order matters: bits [2:1] pick width, bit 0 picks signedness.
  typedef enum logic [MODE_W-1:0] {
    CM_U64    = 4'd0,
    CM_S64    = 4'd1,
    CM_U32    = 4'd2,
    CM_S32    = 4'd3,
    CM_U16    = 4'd4,
    CM_S16    = 4'd5,
    CM_U8     = 4'd6,
    CM_S8     = 4'd7,
    CM_RANGE1 = 4'd8,
    CM_RANGE2 = 4'd9,
    CM_BYTEEQ = 4'd10
  } cmp_mode_e;

  function automatic logic is_magnitude(logic [MODE_W-1:0] m);
    return m <= CM_S8;
  endfunction

endpackage

// File: rtl/cmpu_magnitude.sv
module cmpu_magnitude #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        wsel,
  input  logic              sgn,
  output logic              lt,
  output logic              gt,
  output logic              eq
);

  localparam int EXT_W = DATA_W + 1;

  // Keep the low DATA_W>>wsel bits; fill the rest with the sign or zero.
  function automatic logic signed [EXT_W-1:0] widen(
    logic [DATA_W-1:0] v, logic [1:0] ws, logic s);
    logic [EXT_W-1:0] r;
    int w;
    w = DATA_W >> ws;
    for (int i = 0; i < EXT_W; i++) begin
      if (i < w) r[i] = v[i];
      else       r[i] = s & v[w-1];
    end
    return signed'(r);
  endfunction

  logic signed [EXT_W-1:0] ea;
  logic signed [EXT_W-1:0] eb;

  assign ea = widen(a, wsel, sgn);
  assign eb = widen(b, wsel, sgn);
  assign lt = ea < eb;
  assign gt = ea > eb;
  assign eq = ea == eb;

endmodule

// File: rtl/cmpu_byte_range.sv
module cmpu_byte_range #(
  parameter int NUM_RANGES = 2,
  parameter int BYTE_W     = 8
) (
  input  logic [BYTE_W-1:0]              probe,
  input  logic [2*BYTE_W*NUM_RANGES-1:0] bounds,
  input  logic [NUM_RANGES-1:0]          range_en,
  output logic [NUM_RANGES-1:0]          range_hits,
  output logic                           hit
);

  function automatic logic in_range(logic [BYTE_W-1:0] p,
                                    logic [BYTE_W-1:0] lo,
                                    logic [BYTE_W-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    logic [BYTE_W-1:0] lo_b;
    logic [BYTE_W-1:0] hi_b;
    assign lo_b = bounds[2*BYTE_W*r +: BYTE_W];
    assign hi_b = bounds[2*BYTE_W*r + BYTE_W +: BYTE_W];
    assign range_hits[r] = range_en[r] & in_range(probe, lo_b, hi_b);
  end

  assign hit = |range_hits;

endmodule

// File: rtl/cmpu_byte_match.sv
module cmpu_byte_match #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] probe,
  input  logic [DATA_W-1:0] lanes,
  output logic [DATA_W/BYTE_W-1:0] lane_hits,
  output logic              hit
);

  localparam int NBYTES = DATA_W / BYTE_W;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign lane_hits[i] = lanes[BYTE_W*i +: BYTE_W] == probe;
  end

  assign hit = |lane_hits;

endmodule

// File: rtl/cmpu_core.sv
module cmpu_core
  import cmpu_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int IMM_W      = 16,
  parameter int NUM_RANGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [3:0]        mode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              so_in,
  output logic              res_valid,
  output logic [3:0]        cond
);

  localparam int RANGE_BITS = 2 * BYTE_W * NUM_RANGES;
  localparam int NBYTES     = DATA_W / BYTE_W;

  // Second operand after immediate selection.
  logic [DATA_W-1:0] src_b;
  assign src_b = use_imm ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm} : opnd_b;

  // Mode decode, named for the checker.
  logic mode_is_mag;
  logic is_rng1;
  logic is_rng2;
  logic is_beq;
  assign mode_is_mag = is_magnitude(mode);
  assign is_rng1     = mode == CM_RANGE1;
  assign is_rng2     = mode == CM_RANGE2;
  assign is_beq      = mode == CM_BYTEEQ;

  logic mag_lt;
  logic mag_gt;
  logic mag_eq;

  cmpu_magnitude #(.DATA_W(DATA_W)) u_mag (
    .a    (opnd_a),
    .b    (src_b),
    .wsel (mode[2:1]),
    .sgn  (mode[0]),
    .lt   (mag_lt),
    .gt   (mag_gt),
    .eq   (mag_eq)
  );

  logic [NUM_RANGES-1:0] range_en;
  logic [NUM_RANGES-1:0] range_hits;
  logic                  rng_hit;

  // Range 0 serves both range modes; further ranges only the dual mode.
  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_en
    if (r == 0) begin : g_first
      assign range_en[r] = is_rng1 | is_rng2;
    end else begin : g_rest
      assign range_en[r] = is_rng2;
    end
  end

  cmpu_byte_range #(.NUM_RANGES(NUM_RANGES), .BYTE_W(BYTE_W)) u_rng (
    .probe      (opnd_a[BYTE_W-1:0]),
    .bounds     (src_b[RANGE_BITS-1:0]),
    .range_en   (range_en),
    .range_hits (range_hits),
    .hit        (rng_hit)
  );

  logic [NBYTES-1:0] lane_hits;
  logic              beq_hit;

  cmpu_byte_match #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_beq (
    .probe     (opnd_a[BYTE_W-1:0]),
    .lanes     (src_b),
    .lane_hits (lane_hits),
    .hit       (beq_hit)
  );

  logic [COND_W-1:0] next_cond;

  always_comb begin
    next_cond = '0;
    if (mode_is_mag) begin
      next_cond[CB_LT] = mag_lt;
      next_cond[CB_GT] = mag_gt;
      next_cond[CB_EQ] = mag_eq;
      next_cond[CB_SO] = so_in;
    end else if (is_rng1 || is_rng2) begin
      next_cond[CB_GT] = rng_hit;
    end else if (is_beq) begin
      next_cond[CB_GT] = beq_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      cond      <= '0;
    end else begin
      res_valid <= issue_valid;
      if (issue_valid) cond <= next_cond;
    end
  end

endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       issue_valid,
  input logic [3:0] mode,
  input logic       so_in,
  input logic       res_valid,
  input logic [3:0] cond,
  input logic       mode_is_mag,
  input logic       mag_lt,
  input logic       mag_gt,
  input logic       mag_eq
);

  AST_ISSUE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> res_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !res_valid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(cond)); // R10

  AST_MAG_SINGLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(mode) <= 4'd7) |-> $onehot(cond[3:1])); // R3

  AST_SO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(mode) <= 4'd7) |-> cond[0] == $past(so_in)); // R3

  AST_BYTE_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(mode) >= 4'd8 && $past(mode) <= 4'd10)
      |-> (!cond[3] && cond[1:0] == 2'b00)); // R6

  AST_SPARE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(mode) >= 4'd11) |-> cond == 4'b0000); // R9

  AST_MAG_UNIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_mag |-> $onehot({mag_lt, mag_gt, mag_eq})); // R3

endmodule

bind cmpu_core cmpu_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .mode        (mode),
  .so_in       (so_in),
  .res_valid   (res_valid),
  .cond        (cond),
  .mode_is_mag (mode_is_mag),
  .mag_lt      (mag_lt),
  .mag_gt      (mag_gt),
  .mag_eq      (mag_eq)
);

// File: tb/cmpu_core_test.sv
module cmpu_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 30;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  mode;
    logic        use_imm;
    logic        so;
    logic [63:0] a;
    logic [63:0] b;
    logic [15:0] imm;
    logic [3:0]  exp;
  } vec_t;

  // exp is {LT, GT, EQ, SO}
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  4'd0,  1'b0, 1'b0, 64'h1, 64'h2, 16'h0, 4'b1000},                  // R3
    '{4'd4,  4'd0,  1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 4'b0100}, // R4
    '{4'd4,  4'd1,  1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 16'h0, 4'b1000}, // R4
    '{4'd3,  4'd1,  1'b0, 1'b1, 64'h5, 64'h5, 16'h0, 4'b0011},                  // R3
    '{4'd4,  4'd2,  1'b0, 1'b0, 64'h1234_5678_0000_0001, 64'h2, 16'h0, 4'b1000}, // R4
    '{4'd4,  4'd3,  1'b0, 1'b0, 64'h8000_0000, 64'h0, 16'h0, 4'b1000},          // R4
    '{4'd4,  4'd2,  1'b0, 1'b0, 64'h8000_0000, 64'h0, 16'h0, 4'b0100},          // R4
    '{4'd4,  4'd4,  1'b0, 1'b0, 64'hFFFF_0000_0000_8000, 64'h7FFF, 16'h0, 4'b0100}, // R4
    '{4'd4,  4'd5,  1'b0, 1'b0, 64'hFFFF_0000_0000_8000, 64'h7FFF, 16'h0, 4'b1000}, // R4
    '{4'd4,  4'd6,  1'b0, 1'b0, 64'h80, 64'h7F, 16'h0, 4'b0100},                // R4
    '{4'd4,  4'd7,  1'b0, 1'b0, 64'h80, 64'h7F, 16'h0, 4'b1000},                // R4
    '{4'd3,  4'd7,  1'b0, 1'b1, 64'hAB00_00FF, 64'h11FF, 16'h0, 4'b0011},       // R3
    '{4'd5,  4'd1,  1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8000, 4'b0100}, // R5
    '{4'd5,  4'd0,  1'b1, 1'b0, 64'h1_0000, 64'h0, 16'h8000, 4'b1000},          // R5
    '{4'd6,  4'd8,  1'b0, 1'b1, 64'h41, 64'h5A41, 16'h0, 4'b0100},              // R6
    '{4'd6,  4'd8,  1'b0, 1'b0, 64'h5B, 64'h5A41, 16'h0, 4'b0000},              // R6
    '{4'd6,  4'd8,  1'b0, 1'b0, 64'h5A, 64'h5A41, 16'h0, 4'b0100},              // R6
    '{4'd6,  4'd8,  1'b0, 1'b0, 64'h40, 64'h5A41, 16'h0, 4'b0000},              // R6
    '{4'd6,  4'd8,  1'b0, 1'b0, 64'h61, 64'h7A61_5A41, 16'h0, 4'b0000},         // R6
    '{4'd7,  4'd9,  1'b0, 1'b0, 64'h61, 64'h7A61_5A41, 16'h0, 4'b0100},         // R7
    '{4'd7,  4'd9,  1'b0, 1'b1, 64'h60, 64'h7A61_5A41, 16'h0, 4'b0000},         // R7
    '{4'd11, 4'd9,  1'b0, 1'b0, 64'h20, 64'h1030_1030, 16'h0, 4'b0000},         // R11
    '{4'd6,  4'd8,  1'b0, 1'b0, 64'hFF00_0000_0000_0041, 64'h5A41, 16'h0, 4'b0100}, // R6
    '{4'd8,  4'd10, 1'b0, 1'b0, 64'h33, 64'h3300_0000_0000_0000, 16'h0, 4'b0100}, // R8
    '{4'd8,  4'd10, 1'b0, 1'b0, 64'h34, 64'h3300_0000_0000_0000, 16'h0, 4'b0000}, // R8
    '{4'd8,  4'd10, 1'b0, 1'b1, 64'h88, 64'h1122_3344_5566_7788, 16'h0, 4'b0100}, // R8
    '{4'd8,  4'd10, 1'b0, 1'b0, 64'h00, 64'h1122_3344_5566_7788, 16'h0, 4'b0000}, // R8
    '{4'd9,  4'd11, 1'b0, 1'b1, 64'h1, 64'h2, 16'h0, 4'b0000},                  // R9
    '{4'd9,  4'd15, 1'b0, 1'b0, 64'h5, 64'h5, 16'h0, 4'b0000},                  // R9
    '{4'd5,  4'd8,  1'b1, 1'b0, 64'h7F, 64'h0, 16'h7F00, 4'b0100}               // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic        so_in = 1'b0;
  logic        res_valid;
  logic [3:0]  cond;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpu_core uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .mode        (mode),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .imm         (imm),
    .use_imm     (use_imm),
    .so_in       (so_in),
    .res_valid   (res_valid),
    .cond        (cond)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode = v.mode; use_imm = v.use_imm; so_in = v.so;
    opnd_a = v.a; opnd_b = v.b; imm = v.imm; issue_valid = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 valid", {3'b0, res_valid}, 4'b0000);
    check("R1 cond", cond, 4'b0000);
    rst_n = 1'b1;

    // Table, back to back issue (R2 latency on every vector)
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R2 valid vec %0d", i), {3'b0, res_valid}, 4'b0001);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), cond, VECS[i].exp);
    end

    // R10: idle with changed inputs keeps cond; R2: no strobe
    issue_valid = 1'b0;
    mode = 4'd0; opnd_a = 64'h1; opnd_b = 64'h2; use_imm = 1'b0;
    @(negedge clk);
    check("R2 idle valid", {3'b0, res_valid}, 4'b0000);
    check("R10 hold", cond, 4'b0100);
    repeat (2) @(negedge clk);
    check("R10 hold later", cond, 4'b0100);

    // R2: no change before the clock edge
    mode = 4'd1; opnd_a = 64'h1; opnd_b = 64'h5; so_in = 1'b0; issue_valid = 1'b1;
    #1;
    check("R2 before edge", cond, 4'b0100);
    @(negedge clk);
    check("R2 after edge", cond, 4'b1000);
    issue_valid = 1'b0;
    @(negedge clk);

    // R1: reset after activity clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 cond after run", cond, 4'b0000);
    check("R1 valid after run", {3'b0, res_valid}, 4'b0000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule